// File: doc/BRIEF.md
# Indexed Mixed-Sign Byte Dot-Product Accumulator

This block updates a vector of 32-bit accumulator lanes. Each lane gains a four-term dot product. The four terms pair four unsigned bytes from a first source vector with four signed bytes from a second source vector. The bytes from the first source come from the lane's own 32-bit word. The bytes from the second source come from a single 32-bit group. A 2-bit group selector picks that group, and the same position is used in every 128-bit segment, so the group is broadcast to all four lanes of its segment.

The vector width `VL` is a parameter and must be a multiple of 128; the default is 512 bits, which gives 16 lanes. There is no lane masking, so every lane is rewritten on every transfer. The sum wraps modulo 2^32. The result sits in an output register behind a valid/ready handshake with one cycle of latency. The register holds its beat while the consumer stalls.

Top module: `idot_top`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: For each lane e, the accepted result is `acc_in` lane e plus the sum over i=0..3 of A-byte times B-byte, and every lane is written.
- R3: Bytes of `src_a` are zero-extended, so 0xFF counts as 255.
- R4: Bytes of `src_b` are sign-extended, so 0x80 counts as -128 and 0xFF counts as -1.
- R5: Byte i of lane e is bits [32*e+8*i+7 : 32*e+8*i] of a vector, with byte 0 in the least significant bits. Lane e takes its A bytes from its own word.
- R6: Lane e takes its B bytes from group s = 4*(e/4) + `grp_sel`. The same group is shared by all four lanes of a 128-bit segment, and each segment uses its own copy of the selected position.
- R7: Lane sums wrap modulo 2^32 with no saturation.
- R8: A beat is accepted when `in_valid` and `in_ready` are both 1. `out_valid` is 1 in the next cycle, and `in_ready` equals `!out_valid || out_ready`. If no new beat is accepted, `out_valid` drops after a cycle with `out_ready` high.
- R9: While `out_valid` is 1 and `out_ready` is 0, `acc_out` and `out_valid` do not change, and new input is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Block can take a beat |
| src_a | input | VL | Unsigned byte source |
| src_b | input | VL | Signed byte source, indexed by group |
| grp_sel | input | 2 | Group position within each 128-bit segment |
| acc_in | input | VL | Old accumulator lanes |
| out_valid | output | 1 | Result beat held |
| out_ready | input | 1 | Consumer takes the result |
| acc_out | output | VL | Updated accumulator lanes |

## Verification
The bench targets several specific faults:
- A design that reads the B group from the lane's own word, or from segment 0 only, fails the per-segment broadcast test. That test fills each group with a distinct value.
- Swapping the signedness of the two sources gives +128 instead of -128, or -1 instead of 255, in the all-0xFF and all-0x80 patterns.
- Placing a lone byte at one position exposes a wrong byte order or lane mapping.
- Accumulating near 0xFFFFFFFF shows whether the sum saturates or wraps.
- During a stall, fresh data is offered while the output is blocked. A design that overwrites its held beat, or that raises `in_ready` while blocked, is caught.

// File: rtl/idot_pkg.sv
package idot_pkg;

    localparam int LANE_W   = 32;
    localparam int SEG_W    = 128;
    localparam int SEG_LANES = SEG_W / LANE_W;

    typedef logic [LANE_W-1:0] lane_t;
    typedef logic [1:0]        grp_t;

    typedef struct packed {
        logic [7:0] b3;
        logic [7:0] b2;
        logic [7:0] b1;
        logic [7:0] b0;
    } quad_t;

    // Unsigned-by-signed byte multiply, 17-bit signed product.
    function automatic logic signed [16:0] mul_us(input logic [7:0] u, input logic [7:0] s);
        logic signed [16:0] uu;
        logic signed [16:0] ss;
        uu = $signed({9'b0, u});
        ss = $signed({{9{s[7]}}, s});
        return uu * ss;
    endfunction

    // Four-way dot product, sign-extended to lane width.
    function automatic lane_t dot_quad(input quad_t ua, input quad_t sb);
        logic signed [18:0] tot;
        tot = 19'(mul_us(ua.b0, sb.b0)) + 19'(mul_us(ua.b1, sb.b1))
            + 19'(mul_us(ua.b2, sb.b2)) + 19'(mul_us(ua.b3, sb.b3));
        return lane_t'({{(LANE_W-19){tot[18]}}, tot});
    endfunction

endpackage

// File: rtl/idot_lane.sv
module idot_lane
    import idot_pkg::*;
(
    input  lane_t a_word,
    input  lane_t b_word,
    input  lane_t acc_word,
    output lane_t sum_word
);
    quad_t qa;
    quad_t qb;

    always_comb begin
        qa = quad_t'(a_word);
        qb = quad_t'(b_word);
        sum_word = acc_word + dot_quad(qa, qb);
    end
endmodule

// File: rtl/idot_lanes.sv
module idot_lanes
    import idot_pkg::*;
#(
    parameter int VL = 512
) (
    input  logic [VL-1:0] src_a,
    input  logic [VL-1:0] src_b,
    input  grp_t          grp_sel,
    input  logic [VL-1:0] acc_in,
    output logic [VL-1:0] acc_next
);
    localparam int NLANE = VL / LANE_W;

    for (genvar e = 0; e < NLANE; e++) begin : g_lane
        localparam int SEG = e / SEG_LANES;
        logic [SEG_W-1:0] seg_b;
        lane_t            b_pick;

        assign seg_b  = src_b[SEG*SEG_W +: SEG_W];
        assign b_pick = seg_b[LANE_W*grp_sel +: LANE_W];

        idot_lane u_lane (
            .a_word   (src_a[e*LANE_W +: LANE_W]),
            .b_word   (b_pick),
            .acc_word (acc_in[e*LANE_W +: LANE_W]),
            .sum_word (acc_next[e*LANE_W +: LANE_W])
        );
    end
endmodule

// File: rtl/idot_outreg.sv
module idot_outreg #(
    parameter int W = 512
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] d,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] q
);
    logic take;

    assign in_ready = !out_valid || out_ready;
    assign take     = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            q         <= '0;
        end else if (take) begin
            out_valid <= 1'b1;
            q         <= d;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/idot_top.sv
module idot_top
    import idot_pkg::*;
#(
    parameter int VL = 512
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [VL-1:0] src_a,
    input  logic [VL-1:0] src_b,
    input  logic [1:0]    grp_sel,
    input  logic [VL-1:0] acc_in,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [VL-1:0] acc_out
);
    if ((VL % SEG_W) != 0 || VL < SEG_W) begin : g_bad_vl
        $error("idot_top: VL must be a nonzero multiple of 128");
    end

    logic [VL-1:0] acc_next;

    idot_lanes #(.VL(VL)) u_lanes (
        .src_a    (src_a),
        .src_b    (src_b),
        .grp_sel  (grp_sel),
        .acc_in   (acc_in),
        .acc_next (acc_next)
    );

    idot_outreg #(.W(VL)) u_oreg (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .d         (acc_next),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .q         (acc_out)
    );
endmodule

// File: rtl/idot_checker.sv
module idot_checker #(
    parameter int VL = 512
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic          in_ready,
    input logic [VL-1:0] src_a,
    input logic [VL-1:0] src_b,
    input logic [1:0]    grp_sel,
    input logic [VL-1:0] acc_in,
    input logic          out_valid,
    input logic          out_ready,
    input logic [VL-1:0] acc_out
);
    logic [31:0] lane0_exp;
    logic [31:0] b_grp;
    int          acc_sum;

    always_comb begin
        b_grp   = src_b[32*grp_sel +: 32];
        acc_sum = 0;
        for (int i = 0; i < 4; i++) begin
            acc_sum = acc_sum + int'(src_a[8*i +: 8])
                              * int'($signed(b_grp[8*i +: 8]));
        end
    end

    always_ff @(posedge clk) begin
        if (in_valid && in_ready) lane0_exp <= acc_in[31:0] + 32'(acc_sum);
    end

    assert_reset_idle_R1: assert property (@(posedge clk) rst |=> !out_valid);

    assert_lane0_sum_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (acc_out[31:0] == lane0_exp));

    assert_accept_latency_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid);

    assert_drain_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && !in_valid) |=> !out_valid);

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(acc_out)));

    assert_blocked_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);
endmodule

bind idot_top idot_checker #(.VL(VL)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .src_a     (src_a),
    .src_b     (src_b),
    .grp_sel   (grp_sel),
    .acc_in    (acc_in),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .acc_out   (acc_out)
);

// File: tb/idot_top_test.sv
module idot_top_test;
    localparam int VL = 512;
    localparam int NL = VL / 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [VL-1:0] src_a = '0;
    logic [VL-1:0] src_b = '0;
    logic [1:0]    grp_sel = '0;
    logic [VL-1:0] acc_in = '0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [VL-1:0] acc_out;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;
    logic [31:0] lcg = 32'h1234_5678;

    always #2.5 clk = ~clk;

    idot_top #(.VL(VL)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .src_a(src_a), .src_b(src_b), .grp_sel(grp_sel), .acc_in(acc_in),
        .out_valid(out_valid), .out_ready(out_ready), .acc_out(acc_out)
    );

    function automatic logic [VL-1:0] model(input logic [VL-1:0] a, input logic [VL-1:0] b,
                                            input logic [1:0] idx, input logic [VL-1:0] acc);
        logic [VL-1:0] r;
        for (int e = 0; e < NL; e++) begin
            int s = (e - (e % 4)) + int'(idx);
            int tot = 0;
            for (int i = 0; i < 4; i++) begin
                int ua = int'(a[32*e + 8*i +: 8]);
                byte sb = byte'(b[32*s + 8*i +: 8]);
                tot += ua * int'(sb);
            end
            r[32*e +: 32] = acc[32*e +: 32] + 32'(tot);
        end
        return r;
    endfunction

    function automatic logic [VL-1:0] rep_byte(input logic [7:0] v);
        return {(VL/8){v}};
    endfunction

    task automatic rnd_vec(output logic [VL-1:0] v);
        for (int k = 0; k < NL; k++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            v[32*k +: 32] = lcg;
        end
    endtask

    task automatic chk_bit(input string req, input logic got, input logic exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    task automatic chk_vec(input string req, input logic [VL-1:0] got, input logic [VL-1:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Send one beat with out_ready high; result is registered on the edge.
    task automatic send(input logic [VL-1:0] a, input logic [VL-1:0] b,
                        input logic [1:0] idx, input logic [VL-1:0] acc);
        @(negedge clk);
        src_a = a; src_b = b; grp_sel = idx; acc_in = acc;
        in_valid = 1'b1; out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk_bit("R1 out_valid", out_valid, 1'b0);
        chk_bit("R1 in_ready", in_ready, 1'b1);
    endtask

    task automatic t_random;
        logic [VL-1:0] a, b, acc;
        for (int idx = 0; idx < 4; idx++) begin
            rnd_vec(a); rnd_vec(b); rnd_vec(acc);
            send(a, b, 2'(idx), acc);
            chk_bit("R8 valid after accept", out_valid, 1'b1);
            chk_vec("R2 R6 random vector", acc_out, model(a, b, 2'(idx), acc));
        end
    endtask

    task automatic t_unsigned_a;
        send(rep_byte(8'hFF), rep_byte(8'h01), 2'd0, '0);
        chk_vec("R3 A=0xFF", acc_out, {NL{32'd1020}});
    endtask

    task automatic t_signed_b;
        send(rep_byte(8'h01), rep_byte(8'h80), 2'd2, '0);
        chk_vec("R4 B=0x80", acc_out, {NL{32'hFFFF_FE00}});
        send(rep_byte(8'hFF), rep_byte(8'hFF), 2'd1, '0);
        chk_vec("R4 A=0xFF B=0xFF", acc_out, {NL{32'hFFFF_FC04}});
    endtask

    task automatic t_byte_pos;
        logic [VL-1:0] a, exp;
        a = '0; a[47:40] = 8'd3;
        exp = '0; exp[63:32] = 32'd3;
        send(a, rep_byte(8'h01), 2'd0, '0);
        chk_vec("R5 lone byte lane1 byte1", acc_out, exp);
    endtask

    task automatic t_broadcast;
        logic [VL-1:0] b, exp;
        for (int g = 0; g < NL; g++) b[32*g +: 32] = {4{8'(g + 1)}};
        for (int idx = 0; idx < 4; idx++) begin
            for (int e = 0; e < NL; e++) exp[32*e +: 32] = 32'(4 * ((e - e % 4) + idx + 1));
            send(rep_byte(8'h01), b, 2'(idx), '0);
            chk_vec("R6 segment broadcast", acc_out, exp);
        end
    endtask

    task automatic t_wrap;
        send(rep_byte(8'hFF), rep_byte(8'h7F), 2'd3, {NL{32'hFFFF_FFFF}});
        chk_vec("R7 wrap", acc_out, {NL{32'h0001_FA03}});
    endtask

    task automatic t_stall;
        logic [VL-1:0] a, b, acc, a2, exp1;
        rnd_vec(a); rnd_vec(b); rnd_vec(acc); rnd_vec(a2);
        exp1 = model(a, b, 2'd1, acc);
        @(negedge clk);
        src_a = a; src_b = b; grp_sel = 2'd1; acc_in = acc;
        in_valid = 1'b1; out_ready = 1'b0;
        @(negedge clk);
        chk_bit("R8 valid under stall", out_valid, 1'b1);
        chk_bit("R9 in_ready low when blocked", in_ready, 1'b0);
        src_a = a2; grp_sel = 2'd2;
        @(negedge clk);
        @(negedge clk);
        chk_vec("R9 held beat", acc_out, exp1);
        chk_bit("R9 still valid", out_valid, 1'b1);
        in_valid = 1'b0; out_ready = 1'b1;
        @(negedge clk);
        chk_bit("R8 drained", out_valid, 1'b0);
        chk_bit("R8 ready after drain", in_ready, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_random();
        t_unsigned_a();
        t_signed_b();
        t_byte_pos();
        t_broadcast();
        t_wrap();
        t_stall();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule